// File: doc/BRIEF.md
# Instruction Fetch and Sub-operation Dispatcher

This block reads instruction words from a bytecode image and turns each one into a bundle of small sub-operations. Each sub-operation goes to exactly one consumer: memory, control flow, gas accounting, storage, side-effect collection or the arithmetic chiplet. The image holds the bytecode of every call back to back. Each call's region is padded with zero words to a fixed instruction count, so a fetch address is `cp * MAX_INSTR + pc`. The surrounding control flow unit supplies the call pointer `cp` and the program counter `pc`. It advances them when the dispatcher issues a control sub-operation, and it holds them while `busy` is high.

The image is filled through a plain write port before execution. Each cycle in which `en` is high fetches one word, decodes it with a fixed table, and registers the resulting bundle onto the dispatch outputs in the following cycle. A cycle stamp goes with the bundle so that consumers can match their work to it. Most opcodes need one cycle. The block copy opcode needs one cycle per word, so a step counter walks through it and `busy` is raised until the last step.

Top module: `ifetch_decode`

## Requirements
- R1: After reset, all dispatch valid bits, `err`, `busy`, `tag_out` and `clk_tag` are zero, and every image word reads as zero.
- R2: A word written at image address A is fetched when `cp * MAX_INSTR + pc` equals A. Unwritten words are zero and decode as HALT (opcode 0x00).
- R3: The word layout is opcode [63:56], type tag [55:48], operand A [47:32], operand B [31:16] and operand C [15:0]. ADD (0x01) and SUB (0x02) issue the following in one bundle: a load into register 0 from A in slot 0, a load into register 1 from B in slot 1, an ALU operation (`alu_fn` 0 for add, 1 for sub), a store of register 2 to C in slot 2, and a control step (`ctl_op` 0).
- R4: JUMP (0x10) issues only a control jump (`ctl_op` 1, target = A) plus gas. HALT (0x00) issues only a control halt (`ctl_op` 2) plus gas.
- R5: SLOAD (0x20) loads register 0 from A in slot 0, issues a storage read, stores register 1 to C in slot 2, and steps. SSTORE (0x21) loads register 0 from A and register 1 from B, issues a storage write (`sto_wr` 1), and steps.
- R6: EMIT (0x30) loads register 0 from A in slot 0, issues a side-effect push, and steps.
- R7: COPY (0x40) runs for N = B[7:0] steps, with zero treated as one. Step k loads register 0 from A+k in slot 0 and stores register 0 to C+k in slot 2. `busy` stays high after every step but the last, and only the last step issues the control step.
- R8: Gas is issued once per instruction, on its first step, with costs HALT 0, ADD 3, SUB 3, JUMP 1, SLOAD 20, SSTORE 40, EMIT 8, COPY 5.
- R9: An opcode outside the table, or `pc` of MAX_INSTR or more, raises `err` and issues no sub-operation, with `tag_out` zero.
- R10: A cycle with `en` low yields a bundle with every valid bit and `err` low, and it leaves `busy` and the step position unchanged.
- R11: Each bundle carries `clk_tag` equal to the number of enabled cycles before it. The tag does not change across idle cycles.
- R12: The bundle for an enabled cycle appears on the outputs after the next rising edge. `tag_out` carries the instruction's type tag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Image write strobe |
| wr_addr | input | ADDR_W | Image write address |
| wr_data | input | 64 | Image write word |
| en | input | 1 | Fetch and issue this cycle |
| cp | input | CP_W | Call pointer |
| pc | input | PC_W | Program counter within the call |
| mem_vld | output | 3 | Memory slot valid bits |
| mem_wr | output | 3 | Memory slot is a store |
| mem_reg | output | 6 | Register index per slot, 2 bits each |
| mem_addr | output | 48 | Memory address per slot, 16 bits each |
| alu_vld | output | 1 | ALU sub-operation valid |
| alu_fn | output | 2 | ALU function |
| ctl_vld | output | 1 | Control sub-operation valid |
| ctl_op | output | 2 | 0 step, 1 jump, 2 halt |
| ctl_tgt | output | 16 | Jump target |
| gas_vld | output | 1 | Gas sub-operation valid |
| gas_cost | output | 8 | Gas amount |
| sto_vld | output | 1 | Storage sub-operation valid |
| sto_wr | output | 1 | Storage write |
| sfx_vld | output | 1 | Side-effect push valid |
| tag_out | output | 8 | Instruction type tag |
| clk_tag | output | CLK_W | Bundle cycle stamp |
| err | output | 1 | Decode or address error |
| busy | output | 1 | Multi-step instruction in progress |

## Verification
The properties assume that the caller keeps `cp` and `pc` fixed while `busy` is high. They also assume that the word being executed is not rewritten in that window, because the step sequencer refetches that word on every step. The stimulus moves `cp` and `pc` only when the model predicts that `busy` is low, including across a deliberate idle pause inside a copy. It writes the image only while `en` is low. Random `pc` values reach past the padded region on purpose to exercise the error path.

// File: rtl/ifetch_decode.sv
`timescale 1ns/1ps
module ifetch_decode #(
  parameter int NCALL     = 4,
  parameter int MAX_INSTR = 12,
  parameter int CNT_W     = 8,
  parameter int CLK_W     = 16,
  localparam int CP_W   = $clog2(NCALL),
  localparam int PC_W   = $clog2(MAX_INSTR),
  localparam int DEPTH  = NCALL * MAX_INSTR,
  localparam int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [63:0]       wr_data,
  input  logic              en,
  input  logic [CP_W-1:0]   cp,
  input  logic [PC_W-1:0]   pc,
  output logic [2:0]        mem_vld,
  output logic [2:0]        mem_wr,
  output logic [5:0]        mem_reg,
  output logic [47:0]       mem_addr,
  output logic              alu_vld,
  output logic [1:0]        alu_fn,
  output logic              ctl_vld,
  output logic [1:0]        ctl_op,
  output logic [15:0]       ctl_tgt,
  output logic              gas_vld,
  output logic [7:0]        gas_cost,
  output logic              sto_vld,
  output logic              sto_wr,
  output logic              sfx_vld,
  output logic [7:0]        tag_out,
  output logic [CLK_W-1:0]  clk_tag,
  output logic              err,
  output logic              busy
);
  localparam logic [7:0] OP_HALT = 8'h00, OP_ADD = 8'h01, OP_SUB = 8'h02, OP_JUMP = 8'h10,
                         OP_SLOAD = 8'h20, OP_SSTORE = 8'h21, OP_EMIT = 8'h30, OP_COPY = 8'h40;
  localparam logic [1:0] CTL_STEP = 2'd0, CTL_JUMP = 2'd1, CTL_HALT = 2'd2;

  logic [63:0]      img [DEPTH];
  logic [CNT_W-1:0] step;
  logic [CLK_W-1:0] cyc;

  wire              pc_ok = {1'b0, pc} < (PC_W+1)'(MAX_INSTR);
  wire [ADDR_W-1:0] faddr = ADDR_W'(cp) * ADDR_W'(MAX_INSTR) + ADDR_W'(pc);
  wire [63:0]       word  = pc_ok ? img[faddr] : 64'd0;
  wire [7:0]        opc   = word[63:56];
  wire [15:0]       opa   = word[47:32];
  wire [15:0]       opb   = word[31:16];
  wire [15:0]       opc_c = word[15:0];
  wire [CNT_W-1:0]  cnt   = opb[CNT_W-1:0];
  wire [CNT_W-1:0]  lastk = (cnt == '0) ? '0 : cnt - 1'b1;
  wire              first = step == '0;

  logic [2:0]       n_mv, n_mw;
  logic [5:0]       n_mr;
  logic [47:0]      n_ma;
  logic             n_av, n_cv, n_gv, n_sv, n_sw, n_fv, n_err, n_busy;
  logic [1:0]       n_af, n_co;
  logic [15:0]      n_ct;
  logic [7:0]       n_gc;
  logic [CNT_W-1:0] n_step;

  always_comb begin
    n_mv = '0; n_mw = '0; n_mr = '0; n_ma = '0;
    n_av = 1'b0; n_af = '0; n_cv = 1'b0; n_co = CTL_STEP; n_ct = '0;
    n_gv = 1'b0; n_gc = '0; n_sv = 1'b0; n_sw = 1'b0; n_fv = 1'b0;
    n_err = 1'b0; n_busy = busy; n_step = step;
    if (en) begin
      n_busy = 1'b0; n_step = '0;
      if (!pc_ok) n_err = 1'b1;
      else begin
        case (opc)
          OP_HALT: begin
            n_cv = 1'b1; n_co = CTL_HALT; n_gv = 1'b1;
          end
          OP_ADD, OP_SUB: begin
            n_mv = 3'b111; n_mw = 3'b100; n_mr = {2'd2, 2'd1, 2'd0}; n_ma = {opc_c, opb, opa};
            n_av = 1'b1; n_af = (opc == OP_SUB) ? 2'd1 : 2'd0;
            n_cv = 1'b1; n_gv = 1'b1; n_gc = 8'd3;
          end
          OP_JUMP: begin
            n_cv = 1'b1; n_co = CTL_JUMP; n_ct = opa; n_gv = 1'b1; n_gc = 8'd1;
          end
          OP_SLOAD: begin
            n_mv = 3'b101; n_mw = 3'b100; n_mr = {2'd1, 2'd0, 2'd0}; n_ma = {opc_c, 16'd0, opa};
            n_sv = 1'b1; n_cv = 1'b1; n_gv = 1'b1; n_gc = 8'd20;
          end
          OP_SSTORE: begin
            n_mv = 3'b011; n_mr = {2'd0, 2'd1, 2'd0}; n_ma = {16'd0, opb, opa};
            n_sv = 1'b1; n_sw = 1'b1; n_cv = 1'b1; n_gv = 1'b1; n_gc = 8'd40;
          end
          OP_EMIT: begin
            n_mv = 3'b001; n_ma = {32'd0, opa};
            n_fv = 1'b1; n_cv = 1'b1; n_gv = 1'b1; n_gc = 8'd8;
          end
          OP_COPY: begin
            n_mv = 3'b101; n_mw = 3'b100;
            n_ma = {opc_c + 16'(step), 16'd0, opa + 16'(step)};
            n_gv = first; n_gc = first ? 8'd5 : 8'd0;
            if (step == lastk) n_cv = 1'b1;
            else begin
              n_busy = 1'b1; n_step = step + 1'b1;
            end
          end
          default: n_err = 1'b1;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) img[i] <= '0;
    end else if (wr_en && 32'(wr_addr) < DEPTH) begin
      img[wr_addr] <= wr_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_vld <= '0; mem_wr <= '0; mem_reg <= '0; mem_addr <= '0;
      alu_vld <= 1'b0; alu_fn <= '0; ctl_vld <= 1'b0; ctl_op <= '0; ctl_tgt <= '0;
      gas_vld <= 1'b0; gas_cost <= '0; sto_vld <= 1'b0; sto_wr <= 1'b0; sfx_vld <= 1'b0;
      tag_out <= '0; clk_tag <= '0; err <= 1'b0; busy <= 1'b0; step <= '0; cyc <= '0;
    end else begin
      mem_vld <= n_mv; mem_wr <= n_mw; mem_reg <= n_mr; mem_addr <= n_ma;
      alu_vld <= n_av; alu_fn <= n_af; ctl_vld <= n_cv; ctl_op <= n_co; ctl_tgt <= n_ct;
      gas_vld <= n_gv; gas_cost <= n_gc; sto_vld <= n_sv; sto_wr <= n_sw; sfx_vld <= n_fv;
      tag_out <= (en && !n_err) ? word[55:48] : 8'd0;
      err <= n_err; busy <= n_busy; step <= n_step;
      if (en) begin
        clk_tag <= cyc;
        cyc     <= cyc + 1'b1;
      end
    end
  end
endmodule

// File: rtl/ifetch_decode_chk.sv
`timescale 1ns/1ps
module ifetch_decode_chk #(
  parameter int CLK_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             en,
  input logic [2:0]       mem_vld,
  input logic [2:0]       mem_wr,
  input logic [5:0]       mem_reg,
  input logic             alu_vld,
  input logic             ctl_vld,
  input logic             gas_vld,
  input logic             sto_vld,
  input logic             sfx_vld,
  input logic [CLK_W-1:0] clk_tag,
  input logic             err,
  input logic             busy
);
  wire any_vld = (mem_vld != 3'b000) || alu_vld || ctl_vld || gas_vld || sto_vld || sfx_vld;

  AST_ERR_QUIET: assert property (@(posedge clk) disable iff (!rst_n) err |-> !any_vld); // R9
  AST_IDLE_SILENT: assert property (@(posedge clk) disable iff (!rst_n) !en |=> (!any_vld && !err)); // R10
  AST_BUSY_NO_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n) busy |-> !ctl_vld); // R7
  AST_GAS_ONCE: assert property (@(posedge clk) disable iff (!rst_n) busy |=> !gas_vld); // R8
  AST_ALU_STORES: assert property (@(posedge clk) disable iff (!rst_n)
    alu_vld |-> (mem_vld[2] && mem_wr[2] && mem_reg[5:4] == 2'd2)); // R3
  AST_STORAGE_ALONE: assert property (@(posedge clk) disable iff (!rst_n) sto_vld |-> (!alu_vld && !sfx_vld)); // R5
  AST_TAG_HOLD: assert property (@(posedge clk) disable iff (!rst_n) !en |=> $stable(clk_tag)); // R11
endmodule

bind ifetch_decode ifetch_decode_chk #(.CLK_W(CLK_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .en(en), .mem_vld(mem_vld), .mem_wr(mem_wr), .mem_reg(mem_reg),
  .alu_vld(alu_vld), .ctl_vld(ctl_vld), .gas_vld(gas_vld), .sto_vld(sto_vld), .sfx_vld(sfx_vld),
  .clk_tag(clk_tag), .err(err), .busy(busy)
);

// File: tb/ifetch_decode_tb_top.sv
`timescale 1ns/1ps
module ifetch_decode_tb_top;
  localparam int NI = 12;
  localparam int NC = 4;
  localparam int EW = 105;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [5:0]  wr_addr = '0;
  logic [63:0] wr_data = '0;
  logic        en = 1'b0;
  logic [1:0]  cp = '0;
  logic [3:0]  pc = '0;
  logic [2:0]  mem_vld, mem_wr;
  logic [5:0]  mem_reg;
  logic [47:0] mem_addr;
  logic        alu_vld, ctl_vld, gas_vld, sto_vld, sto_wr, sfx_vld, err, busy;
  logic [1:0]  alu_fn, ctl_op;
  logic [15:0] ctl_tgt, clk_tag;
  logic [7:0]  gas_cost, tag_out;

  always #4 clk = ~clk;

  ifetch_decode dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .en(en), .cp(cp), .pc(pc), .mem_vld(mem_vld), .mem_wr(mem_wr), .mem_reg(mem_reg),
    .mem_addr(mem_addr), .alu_vld(alu_vld), .alu_fn(alu_fn), .ctl_vld(ctl_vld),
    .ctl_op(ctl_op), .ctl_tgt(ctl_tgt), .gas_vld(gas_vld), .gas_cost(gas_cost),
    .sto_vld(sto_vld), .sto_wr(sto_wr), .sfx_vld(sfx_vld), .tag_out(tag_out),
    .clk_tag(clk_tag), .err(err), .busy(busy)
  );

  wire [EW-1:0] vec = {mem_vld, mem_wr, mem_reg, mem_addr, alu_vld, alu_fn, ctl_vld, ctl_op,
                       ctl_tgt, sto_vld, sto_wr, sfx_vld, tag_out, err, busy, gas_vld, gas_cost};

  int          n_cmp = 0, n_bad = 0;
  logic [63:0] img [NC*NI];
  logic [15:0] ecyc = '0;
  logic        ebusy = 1'b0;

  function automatic logic [EW-1:0] model(input logic [63:0] w, input int p, input int k);
    logic [2:0] mv, mw; logic [1:0] r0, r1, r2, af, co; logic [15:0] a0, a1, a2, ct;
    logic av, cv, sv, sw, fv, er, bz, gv; logic [7:0] gc, tg, op; logic [15:0] oa, ob, oc;
    int n;
    mv = 0; mw = 0; r0 = 0; r1 = 0; r2 = 0; a0 = 0; a1 = 0; a2 = 0; av = 0; af = 0;
    cv = 0; co = 0; ct = 0; sv = 0; sw = 0; fv = 0; er = 0; bz = 0; gv = 0; gc = 0; tg = 0;
    op = w[63:56]; oa = w[47:32]; ob = w[31:16]; oc = w[15:0];
    if (p >= NI) er = 1;
    else case (op)
      8'h00: begin cv = 1; co = 2; gv = 1; end
      8'h01, 8'h02: begin
        mv = 3'b111; mw = 3'b100; r1 = 1; r2 = 2; a0 = oa; a1 = ob; a2 = oc;
        av = 1; af = (op == 8'h02) ? 2'd1 : 2'd0; cv = 1; gv = 1; gc = 3;
      end
      8'h10: begin cv = 1; co = 1; ct = oa; gv = 1; gc = 1; end
      8'h20: begin mv = 3'b101; mw = 3'b100; r2 = 1; a0 = oa; a2 = oc; sv = 1; cv = 1; gv = 1; gc = 20; end
      8'h21: begin mv = 3'b011; r1 = 1; a0 = oa; a1 = ob; sv = 1; sw = 1; cv = 1; gv = 1; gc = 40; end
      8'h30: begin mv = 3'b001; a0 = oa; fv = 1; cv = 1; gv = 1; gc = 8; end
      8'h40: begin
        n = (ob[7:0] == 0) ? 1 : int'(ob[7:0]);
        mv = 3'b101; mw = 3'b100; a0 = oa + 16'(k); a2 = oc + 16'(k);
        gv = (k == 0); gc = (k == 0) ? 8'd5 : 8'd0;
        if (k == n - 1) cv = 1; else bz = 1;
      end
      default: er = 1;
    endcase
    if (!er) tg = w[55:48];
    return {mv, mw, r2, r1, r0, a2, a1, a0, av, af, cv, co, ct, sv, sw, fv, tg, er, bz, gv, gc};
  endfunction

  function automatic string req_of(input logic [63:0] w, input int p);
    if (p >= NI) return "R9";
    case (w[63:56])
      8'h01, 8'h02: return "R3";
      8'h00, 8'h10: return "R4";
      8'h20, 8'h21: return "R5";
      8'h30: return "R6";
      8'h40: return "R7";
      default: return "R9";
    endcase
  endfunction

  task automatic chk(input string r, input logic [127:0] act, input logic [127:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", r, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [63:0] d);
    wr_en = 1; wr_addr = 6'(a); wr_data = d;
    @(negedge clk);
    wr_en = 0;
    if (a < NC*NI) img[a] = d;
  endtask

  task automatic step_once(input int c, input int p, input int k, input string req, output logic bz);
    logic [63:0] w; logic [EW-1:0] e; string r;
    w = (p < NI) ? img[c*NI + p] : 64'd0;
    e = model(w, p, k);
    en = 1; cp = 2'(c); pc = 4'(p);
    @(negedge clk);
    en = 0;
    r = (req == "") ? req_of(w, p) : req;
    chk(r, 128'(vec[EW-1:9]), 128'(e[EW-1:9]));
    chk("R8", 128'(vec[8:0]), 128'(e[8:0]));
    chk("R11", 128'(clk_tag), 128'(ecyc));
    ecyc++;
    bz = e[9]; ebusy = bz;
  endtask

  task automatic run_instr(input int c, input int p, input string req);
    logic bz; int k;
    k = 0;
    do begin
      step_once(c, p, k, req, bz);
      k++;
    end while (bz);
  endtask

  task automatic idle_once();
    en = 0;
    @(negedge clk);
    chk("R10", 128'(vec), 128'({ebusy, 9'd0}));
    chk("R11", 128'(clk_tag), 128'(ecyc - 16'd1));
  endtask

  initial begin
    #(8 * 100000);
    n_bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic bz;
    logic [7:0] ops [9];
    void'($urandom(32'd20240611));
    ops = '{8'h00, 8'h01, 8'h02, 8'h10, 8'h20, 8'h21, 8'h30, 8'h40, 8'h7f};
    for (int i = 0; i < NC*NI; i++) img[i] = '0;
    #20;
    @(negedge clk);
    chk("R1", 128'(vec), 128'(0));
    rst_n = 1;
    @(negedge clk);
    chk("R1", 128'({clk_tag, vec}), 128'(0));

    run_instr(3, 11, "R2");
    wr(12, {8'h01, 8'h05, 16'h0010, 16'h0020, 16'h0030});
    wr(11, {8'h10, 8'h06, 16'h0007, 16'h0000, 16'h0000});
    en = 1; cp = 1; pc = 0;
    #2 chk("R12", 128'(vec), 128'(0));
    en = 0;
    @(negedge clk);
    run_instr(1, 0, "R2");
    run_instr(0, 11, "R2");
    run_instr(1, 0, "");
    wr(29, {8'h02, 8'h09, 16'h1111, 16'h2222, 16'h3333});
    run_instr(2, 5, "");
    wr(0, {8'h20, 8'h03, 16'h0100, 16'h0000, 16'h0200});
    wr(1, {8'h21, 8'h03, 16'h0101, 16'h0102, 16'h0000});
    wr(2, {8'h30, 8'h04, 16'h0400, 16'h0000, 16'h0000});
    wr(3, {8'h40, 8'h01, 16'h0500, 16'h0000, 16'h0600});
    wr(4, {8'h40, 8'h01, 16'hfffe, 16'h0003, 16'h0700});
    wr(5, {8'h7f, 8'h01, 16'h0001, 16'h0002, 16'h0003});
    run_instr(0, 0, "");
    run_instr(0, 1, "");
    run_instr(0, 2, "");
    run_instr(0, 3, "R7");
    step_once(0, 4, 0, "R7", bz);
    idle_once();
    step_once(0, 4, 1, "R7", bz);
    step_once(0, 4, 2, "R7", bz);
    idle_once();
    run_instr(0, 5, "R9");
    run_instr(2, 13, "R9");

    for (int i = 0; i < NC*NI; i++) begin
      logic [63:0] w;
      w = {ops[$urandom % 9], 8'($urandom), 16'($urandom), 16'($urandom), 16'($urandom)};
      if (w[63:56] == 8'h7f) w[63:56] = 8'($urandom);
      if (w[63:56] == 8'h40) w[23:16] = 8'($urandom % 5);
      wr(i, w);
    end
    for (int i = 0; i < 200; i++) begin
      run_instr(int'($urandom % NC), int'($urandom % 16), "");
      if ($urandom % 4 == 0) idle_once();
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule